// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block decides which clock enables of a small microcontroller stay open. The core issues a one-cycle power-save request with a one-bit mode operand. Mode 1 selects Idle, where only the processor clock is gated and the peripherals keep running. Mode 0 selects Sleep, where the processor clock, the system-clocked peripheral clock, the main oscillator and the clock-failure monitor are all turned off. The block drives enables only. The clock gates, the oscillators and the interrupt controller sit outside it.

Two kinds of event wake the block: any pending interrupt that is enabled, or a watchdog time-out. Reset always returns it to the running state. When the block accepts a Sleep entry it clears the watchdog if the watchdog is enabled, and it stores the clock-source selection that was in force. It holds that value so the source can be restored on wake. While the block sleeps, the slow on-chip RC clock stays enabled only if the watchdog needs it. On wake from Sleep, the block waits a fixed number of settle cycles with the oscillator running and every clock gate closed. Only then does it reopen the clocks.

Top module: `powerdown_ctrl`

## Requirements
- R1: After reset, pm_state is 0 (running), cpu_clk_en, per_clk_en, osc_en and clk_mon_en are 1, wdog_clr is 0 and src_restore is 0.
- R2: In the running state, save_req=1 with save_mode=1 and no wake event moves pm_state to 1 (idle) at the next edge. In idle, cpu_clk_en is 0 and per_clk_en, osc_en and clk_mon_en are 1.
- R3: In the running state, save_req=1 with save_mode=0 and no wake event moves pm_state to 2 (sleep) at the next edge. In sleep, cpu_clk_en, per_clk_en, osc_en and clk_mon_en are all 0.
- R4: wdog_clr is 1 exactly in a cycle where a Sleep entry is accepted while wdog_en is 1. An Idle entry never asserts it.
- R5: slow_osc_en is 1 in every state except sleep. In sleep it equals wdog_en.
- R6: src_restore loads src_sel when a Sleep entry is accepted and holds its value at all other times.
- R7: In idle, a wake event returns pm_state to 0 at the next edge.
- R8: In sleep, a wake event moves pm_state to 3 (settling) for exactly SETTLE_CYC cycles, and then to 0. While settling, osc_en is 1 and cpu_clk_en, per_clk_en and clk_mon_en are 0.
- R9: A request that arrives in the same cycle as a wake event is dropped. The block stays running, wdog_clr stays 0 and src_restore is unchanged.
- R10: save_req has no effect outside the running state.
- R11: A wake event is any bit of irq_wake set, or wdog_timeout set. Each alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | One-cycle power-save request |
| save_mode | input | 1 | 0 = Sleep, 1 = Idle |
| irq_wake | input | IRQ_W | Pending-and-enabled interrupt lines |
| wdog_timeout | input | 1 | Watchdog time-out pulse |
| wdog_en | input | 1 | Watchdog is enabled |
| src_sel | input | SRC_W | Clock source currently selected |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| per_clk_en | output | 1 | System-clocked peripheral gate enable |
| osc_en | output | 1 | Main oscillator enable |
| slow_osc_en | output | 1 | Slow RC clock enable |
| clk_mon_en | output | 1 | Clock-failure monitor enable |
| wdog_clr | output | 1 | Watchdog clear strobe |
| src_restore | output | SRC_W | Clock source saved at Sleep entry |
| pm_state | output | 2 | 0 run, 1 idle, 2 sleep, 3 settling |

## Verification
On every cycle, the assertions check the gate set in sleep and the slow clock in sleep. They also check that a watchdog clear is always followed by sleep, that the saved source holds outside the running state, that a wake in idle leads to run, that a dropped entry keeps the block running, that sleep persists with no wake, and, by a counter, the length of the settling window. Only the bench's scenarios can show the exact values that are captured and restored. The same holds for the interplay of watchdog-enabled and watchdog-disabled sleeps, for requests made while idle or settling, and for each wake source on its own. A reference model compared on every clock covers these.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_IDLE   = 2'd1,
        PM_SLEEP  = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic mon;
    } pm_gates_t;

endpackage

// File: rtl/pm_wake_merge.sv
module pm_wake_merge #(
    parameter int IRQ_W = 8
) (
    input  logic [IRQ_W-1:0] irq_wake,
    input  logic             wdog_timeout,
    output logic             wake_evt
);

    logic [IRQ_W:0] chain;

    assign chain[0] = wdog_timeout;

    generate
        for (genvar g = 0; g < IRQ_W; g++) begin : g_or
            assign chain[g+1] = chain[g] | irq_wake[g];
        end
    endgenerate

    assign wake_evt = chain[IRQ_W];

endmodule

// File: rtl/pm_seq.sv
module pm_seq
    import pm_pkg::*;
#(
    parameter int SRC_W      = 3,
    parameter int SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             save_mode,
    input  logic             wake_evt,
    input  logic [SRC_W-1:0] src_sel,
    output pm_state_e        state,
    output logic [SRC_W-1:0] src_hold,
    output logic             sleep_accept
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        pm_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [SRC_W-1:0] src;
    } seq_t;

    seq_t r_d, r_q;
    logic idle_accept;

    always_comb begin
        r_d          = r_q;
        idle_accept  = 1'b0;
        sleep_accept = 1'b0;
        unique case (r_q.st)
            PM_RUN: begin
                if (save_req && !wake_evt) begin
                    if (save_mode) begin
                        idle_accept = 1'b1;
                        r_d.st      = PM_IDLE;
                    end else begin
                        sleep_accept = 1'b1;
                        r_d.st       = PM_SLEEP;
                        r_d.src      = src_sel;
                    end
                end
            end
            PM_IDLE: begin
                if (wake_evt) r_d.st = PM_RUN;
            end
            PM_SLEEP: begin
                if (wake_evt) begin
                    r_d.st  = PM_SETTLE;
                    r_d.cnt = '0;
                end
            end
            PM_SETTLE: begin
                if (r_q.cnt == CNT_LAST) r_d.st = PM_RUN;
                else                     r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.st = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= PM_RUN;
            r_q.cnt <= '0;
            r_q.src <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign src_hold = r_q.src;

endmodule

// File: rtl/pm_gate_map.sv
module pm_gate_map
    import pm_pkg::*;
(
    input  pm_state_e state,
    input  logic      wdog_en,
    input  logic      sleep_accept,
    output pm_gates_t gates,
    output logic      slow_osc_en,
    output logic      wdog_clr
);

    always_comb begin
        unique case (state)
            PM_RUN:    gates = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, mon: 1'b1};
            PM_IDLE:   gates = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, mon: 1'b1};
            PM_SLEEP:  gates = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, mon: 1'b0};
            PM_SETTLE: gates = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, mon: 1'b0};
            default:   gates = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, mon: 1'b0};
        endcase
        slow_osc_en = (state != PM_SLEEP) || wdog_en;
        wdog_clr    = sleep_accept && wdog_en;
    end

endmodule

// File: rtl/powerdown_ctrl.sv
module powerdown_ctrl
    import pm_pkg::*;
#(
    parameter int IRQ_W      = 8,
    parameter int SRC_W      = 3,
    parameter int SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             save_mode,
    input  logic [IRQ_W-1:0] irq_wake,
    input  logic             wdog_timeout,
    input  logic             wdog_en,
    input  logic [SRC_W-1:0] src_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             slow_osc_en,
    output logic             clk_mon_en,
    output logic             wdog_clr,
    output logic [SRC_W-1:0] src_restore,
    output logic [1:0]       pm_state
);

    logic      wake_evt;
    logic      sleep_accept;
    pm_state_e state;
    pm_gates_t gates;

    pm_wake_merge #(.IRQ_W(IRQ_W)) u_wake (
        .irq_wake     (irq_wake),
        .wdog_timeout (wdog_timeout),
        .wake_evt     (wake_evt)
    );

    pm_seq #(.SRC_W(SRC_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .save_req     (save_req),
        .save_mode    (save_mode),
        .wake_evt     (wake_evt),
        .src_sel      (src_sel),
        .state        (state),
        .src_hold     (src_restore),
        .sleep_accept (sleep_accept)
    );

    pm_gate_map u_map (
        .state        (state),
        .wdog_en      (wdog_en),
        .sleep_accept (sleep_accept),
        .gates        (gates),
        .slow_osc_en  (slow_osc_en),
        .wdog_clr     (wdog_clr)
    );

    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign osc_en     = gates.osc;
    assign clk_mon_en = gates.mon;
    assign pm_state   = state;

endmodule

// File: rtl/powerdown_ctrl_chk.sv
module powerdown_ctrl_chk #(
    parameter int IRQ_W      = 8,
    parameter int SRC_W      = 3,
    parameter int SETTLE_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             save_req,
    input logic [IRQ_W-1:0] irq_wake,
    input logic             wdog_timeout,
    input logic             wdog_en,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             slow_osc_en,
    input logic             clk_mon_en,
    input logic             wdog_clr,
    input logic [SRC_W-1:0] src_restore,
    input logic [1:0]       pm_state
);

    localparam int LW = $clog2(SETTLE_CYC + 2) + 1;

    logic          wake_any;
    logic [LW-1:0] settle_len;

    assign wake_any = (|irq_wake) || wdog_timeout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               settle_len <= '0;
        else if (pm_state == 2'd3) settle_len <= settle_len + 1'b1;
        else                      settle_len <= '0;
    end

    // R3
    sleep_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd2) |-> (!cpu_clk_en && !per_clk_en && !osc_en && !clk_mon_en));

    // R5
    slow_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd2 && !wdog_en) |-> !slow_osc_en);

    // R4
    wdog_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_clr |=> (pm_state == 2'd2));

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state != 2'd0) |=> $stable(src_restore));

    // R7
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd1 && wake_any) |=> (pm_state == 2'd0));

    // R9
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd0 && wake_any) |=> (pm_state == 2'd0));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd2 && !wake_any) |=> (pm_state == 2'd2));

    // R8
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd3) |-> (settle_len < LW'(SETTLE_CYC)));

    // R8
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd3 && settle_len == LW'(SETTLE_CYC - 1)) |=> (pm_state == 2'd0));

    // R10
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 2'd1 && save_req && !wake_any) |=> (pm_state == 2'd1));

endmodule

bind powerdown_ctrl powerdown_ctrl_chk #(
    .IRQ_W(IRQ_W), .SRC_W(SRC_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (.*);

// File: tb/test_powerdown_ctrl.sv
`timescale 1ns/1ps
module test_powerdown_ctrl;

    localparam int IRQ_W  = 8;
    localparam int SRC_W  = 3;
    localparam int SETTLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic save_req = 1'b0, save_mode = 1'b0, wdog_timeout = 1'b0, wdog_en = 1'b0;
    logic [IRQ_W-1:0] irq_wake = '0;
    logic [SRC_W-1:0] src_sel = '0;
    logic cpu_clk_en, per_clk_en, osc_en, slow_osc_en, clk_mon_en, wdog_clr;
    logic [SRC_W-1:0] src_restore;
    logic [1:0] pm_state;

    int checks = 0;
    int fails  = 0;
    int m_st   = 0;
    int m_cnt  = 0;
    int m_src  = 0;

    always #2.5 clk = ~clk;

    powerdown_ctrl #(.IRQ_W(IRQ_W), .SRC_W(SRC_W), .SETTLE_CYC(SETTLE)) i_powerdown_ctrl (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .save_mode(save_mode),
        .irq_wake(irq_wake), .wdog_timeout(wdog_timeout), .wdog_en(wdog_en),
        .src_sel(src_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .slow_osc_en(slow_osc_en), .clk_mon_en(clk_mon_en),
        .wdog_clr(wdog_clr), .src_restore(src_restore), .pm_state(pm_state)
    );

    task automatic check_val(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    function automatic string st_tag(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R8";
        endcase
    endfunction

    function automatic bit wake_now();
        return (|irq_wake) || wdog_timeout;
    endfunction

    // compare against the model, then advance one clock
    task automatic cyc();
        string t;
        bit acc;
        #1;
        t   = st_tag(m_st);
        acc = (m_st == 0) && save_req && !save_mode && !wake_now();
        check_val(t, "pm_state", pm_state, m_st);
        check_val(t, "cpu_clk_en", cpu_clk_en, m_st == 0);
        check_val(t, "per_clk_en", per_clk_en, m_st <= 1);
        check_val(t, "osc_en", osc_en, m_st != 2);
        check_val(t, "clk_mon_en", clk_mon_en, m_st <= 1);
        check_val("R5", "slow_osc_en", slow_osc_en, (m_st != 2) || wdog_en);
        check_val("R4", "wdog_clr", wdog_clr, acc && wdog_en);
        check_val("R6", "src_restore", src_restore, m_src);
        @(posedge clk);
        case (m_st)
            0: if (save_req && !wake_now()) begin
                   if (save_mode) m_st = 1;
                   else begin m_st = 2; m_src = int'(src_sel); end
               end
            1: if (wake_now()) m_st = 0;
            2: if (wake_now()) begin m_st = 3; m_cnt = 0; end
            default: if (m_cnt == SETTLE - 1) m_st = 0; else m_cnt++;
        endcase
        @(negedge clk);
        save_req = 1'b0; irq_wake = '0; wdog_timeout = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_val("R1", "reset state", pm_state, 0);
        check_val("R1", "reset gates", {cpu_clk_en, per_clk_en, osc_en, clk_mon_en}, 15);
        check_val("R1", "reset src", src_restore, 0);
        idle_cycles(2);

        // R2 idle entry, R10 request ignored in idle, R11/R7 irq wake
        save_req = 1; save_mode = 1; cyc();
        check_val("R2", "idle state", pm_state, 1);
        idle_cycles(2);
        save_req = 1; save_mode = 0; src_sel = 3'd6; cyc();
        check_val("R10", "req in idle", pm_state, 1);
        irq_wake = 8'h08; cyc();
        check_val("R7", "idle wake", pm_state, 0);

        // R3/R4/R6 sleep with watchdog on, R11 timeout wake, R8 settle
        wdog_en = 1; src_sel = 3'd5; save_req = 1; save_mode = 0; #1;
        check_val("R4", "wdog_clr pulse", wdog_clr, 1);
        cyc();
        check_val("R3", "sleep state", pm_state, 2);
        src_sel = 3'd2; idle_cycles(3);
        check_val("R6", "src kept", src_restore, 5);
        save_req = 1; save_mode = 1; cyc();
        check_val("R10", "req in sleep", pm_state, 2);
        wdog_timeout = 1; cyc();
        check_val("R8", "settle entry", pm_state, 3);
        save_req = 1; save_mode = 0; cyc();
        check_val("R10", "req in settle", pm_state, 3);
        cyc();
        check_val("R8", "settle done", pm_state, 0);

        // R5 sleep with watchdog off, R11 lowest irq bit
        wdog_en = 0; src_sel = 3'd3; save_req = 1; save_mode = 0; #1;
        check_val("R4", "no clr when off", wdog_clr, 0);
        cyc();
        check_val("R5", "slow clk off", slow_osc_en, 0);
        idle_cycles(2);
        irq_wake = 8'h01; cyc();
        idle_cycles(2);
        check_val("R11", "irq bit0 wake", pm_state, 0);

        // R9 cancel by interrupt and by time-out
        wdog_en = 1; src_sel = 3'd7; save_req = 1; save_mode = 0; irq_wake = 8'h80; #1;
        check_val("R9", "cancel no clr", wdog_clr, 0);
        cyc();
        check_val("R9", "cancel stays run", pm_state, 0);
        check_val("R9", "cancel src", src_restore, 3);
        save_req = 1; save_mode = 1; wdog_timeout = 1; cyc();
        check_val("R9", "idle cancel", pm_state, 0);

        // back-to-back: sleep, wake, request right as run resumes
        save_req = 1; save_mode = 0; cyc();
        irq_wake = 8'h10; cyc();
        idle_cycles(2);
        save_req = 1; save_mode = 1; cyc();
        check_val("R2", "idle after settle", pm_state, 1);
        irq_wake = 8'h02; cyc();
        idle_cycles(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule